// File: doc/BRIEF.md
# Four-Source Timer Interrupt Flag and Enable Controller

This block holds the interrupt state for a multi-function timer that has four interrupt sources, named A to D. For each source it keeps a sticky pending flag and an enable bit. A single-cycle event pulse from the timer sets the pending flag of its source. Software can also set a flag by writing a one to it. Software cannot clear a flag through the control register. Flags clear only through a separate write-one-to-clear register.

A flag latches whether or not its source is enabled. Enable bits only decide whether a pending flag contributes to the combined interrupt line. That line is registered, so it changes one clock after the flag and enable state that drives it.

The register bus is a plain control port: address, write strobe, write data and read data. It has no valid/ready handshake and no back-pressure. Every write is accepted in the cycle its strobe is high. Read data is combinational from the address.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset, the control register reads 0x00 and `irq_out` is 0.
- R2: The control register sits at offset 0. Bits 3:0 are the pending flags of sources A, B, C and D (A in bit 0). Bits 7:4 are the enables of A, B, C and D (A in bit 4). A read returns both groups.
- R3: An event pulse on `evt_pulse[i]` sets pending flag i at that clock edge.
- R4: A control-register write with a 1 in bit i (i in 0..3) sets pending flag i.
- R5: A 0 written to a pending bit of the control register leaves that flag unchanged.
- R6: The clear register sits at offset 1. A 1 in bit i (0..3) clears pending flag i, and its bits 7:4 have no effect. The clear register always reads 0x00.
- R7: If an event and a clear hit the same source in the same cycle, the flag ends up 1.
- R8: A source with enable 0 still latches its pending flag on an event but does not raise `irq_out`.
- R9: `irq_out` is the OR over all sources of (pending AND enable), registered, so it follows that state one clock later.
- R10: Control-register writes load bits 7:4 into the enables at any time. Clearing an enable drops the interrupt one clock later while the flag stays set.
- R11: Offsets 2 and 3 read as 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| evt_pulse | input | 4 | Timer event pulses, bit i for source i |
| irq_out | output | 1 | Registered combined interrupt |

## Verification
A corrupted pending or enable bit is visible on the very next read of offset 0. It also shows on `irq_out` exactly one clock after the bad state appears. A flag that drops without a clear write, or ignores a set, therefore shows up within one cycle at the read port and within two cycles on the interrupt line. The bench reads the control register back after each stimulus and checks `irq_out` on both sides of the one-clock register delay. This catches errors in the latency as well as in the level.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int NUM_SRC   = 4;
  localparam int DATA_W    = 2 * NUM_SRC;
  localparam int ADDR_W    = 2;
  localparam logic [ADDR_W-1:0] CTRL_OFS = 2'd0;
  localparam logic [ADDR_W-1:0] CLR_OFS  = 2'd1;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  typedef struct packed {
    logic     ctrl_wr;
    logic     clr_wr;
    src_vec_t set_mask;
    src_vec_t clr_mask;
    src_vec_t en_data;
  } bus_cmd_t;
endpackage

// File: rtl/tirq_bus_decode.sv
module tirq_bus_decode
  import tmr_irq_pkg::*;
#(
  parameter int NSRC = NUM_SRC,
  parameter int AW   = ADDR_W,
  localparam int DW  = 2 * NSRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            wr,
  input  logic [DW-1:0]   wdata,
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] en,
  output logic            ctrl_wr,
  output logic            clr_wr,
  output logic [NSRC-1:0] set_mask,
  output logic [NSRC-1:0] clr_mask,
  output logic [NSRC-1:0] en_data,
  output logic [DW-1:0]   rdata
);
  logic hit_ctrl, hit_clr;

  always_comb begin
    hit_ctrl = (addr == AW'(CTRL_OFS));
    hit_clr  = (addr == AW'(CLR_OFS));
    ctrl_wr  = wr && hit_ctrl;
    clr_wr   = wr && hit_clr;
    set_mask = ctrl_wr ? wdata[NSRC-1:0] : '0;
    clr_mask = clr_wr  ? wdata[NSRC-1:0] : '0;
    en_data  = wdata[DW-1:NSRC];
    rdata    = hit_ctrl ? {en, pend} : '0;
  end

  assert_single_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_wr, clr_wr}));
  assert_clr_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(CLR_OFS)) |-> (rdata == '0));
  assert_unmapped_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != AW'(CTRL_OFS) && addr != AW'(CLR_OFS)) |-> (rdata == '0));
endmodule

// File: rtl/tirq_pend_bank.sv
module tirq_pend_bank
  import tmr_irq_pkg::*;
#(
  parameter int NSRC = NUM_SRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] set_mask,
  input  logic [NSRC-1:0] clr_mask,
  output logic [NSRC-1:0] pend
);
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    logic nxt;
    always_comb begin
      if (evt[i] || set_mask[i]) nxt = 1'b1;   // a set always beats a clear
      else if (clr_mask[i])      nxt = 1'b0;
      else                       nxt = pend[i];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) pend[i] <= 1'b0;
      else        pend[i] <= nxt;
    end

    assert_event_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> pend[i]);
    assert_sw_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      set_mask[i] |=> pend[i]);
    assert_hold_unless_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[i] && !clr_mask[i]) |=> pend[i]);
    assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[i] && clr_mask[i]) |=> pend[i]);
    assert_fall_needs_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend[i]) |-> $past(clr_mask[i]));
  end
endmodule

// File: rtl/tirq_enable_reg.sv
module tirq_enable_reg
  import tmr_irq_pkg::*;
#(
  parameter int NSRC = NUM_SRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [NSRC-1:0] din,
  output logic [NSRC-1:0] en
);
  always_ff @(posedge clk) begin
    if (!rst_n)    en <= '0;
    else if (load) en <= din;
  end

  assert_enable_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (en == $past(din)));
  assert_enable_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(en));
endmodule

// File: rtl/tirq_irq_merge.sv
module tirq_irq_merge
  import tmr_irq_pkg::*;
#(
  parameter int NSRC = NUM_SRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] en,
  output logic            irq
);
  logic any_live;
  always_comb any_live = |(pend & en);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= any_live;
  end

  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    any_live |=> irq);
  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & en) == '0) |=> !irq);
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
#(
  parameter int NSRC = NUM_SRC,
  parameter int AW   = ADDR_W,
  localparam int DW  = 2 * NSRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] evt_pulse,
  output logic            irq_out
);
  logic            ctrl_wr, clr_wr;
  logic [NSRC-1:0] set_mask, clr_mask, en_data, pend, en;

  tirq_bus_decode #(.NSRC(NSRC), .AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .pend(pend), .en(en), .ctrl_wr(ctrl_wr), .clr_wr(clr_wr),
    .set_mask(set_mask), .clr_mask(clr_mask), .en_data(en_data), .rdata(bus_rdata)
  );

  tirq_pend_bank #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt(evt_pulse), .set_mask(set_mask),
    .clr_mask(clr_mask), .pend(pend)
  );

  tirq_enable_reg #(.NSRC(NSRC)) u_en (
    .clk(clk), .rst_n(rst_n), .load(ctrl_wr), .din(en_data), .en(en)
  );

  tirq_irq_merge #(.NSRC(NSRC)) u_merge (
    .clk(clk), .rst_n(rst_n), .pend(pend), .en(en), .irq(irq_out)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!irq_out && pend == '0 && en == '0));
endmodule

// File: tb/test_tmr_irq_ctrl.sv
module test_tmr_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] evt_pulse = '0;
  logic       irq_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tmr_irq_ctrl i_tmr_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
    .irq_out(irq_out)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk);
    evt_pulse = m;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd_reg(2'd0, v);
    chk(v, 8'h00, "R1 control after reset");
    chk({7'd0, irq_out}, 8'h00, "R1 irq after reset");
  endtask

  task automatic t_event_disabled;
    logic [7:0] v;
    pulse(4'b0001);
    rd_reg(2'd0, v);
    chk(v, 8'h01, "R3 event latches flag A");
    @(negedge clk);
    chk({7'd0, irq_out}, 8'h00, "R8 disabled source raises no irq");
  endtask

  task automatic t_sw_set;
    logic [7:0] v;
    wr_reg(2'd0, 8'h0A);
    rd_reg(2'd0, v);
    chk(v, 8'h0B, "R4 R2 software sets B and D");
  endtask

  task automatic t_write_zero;
    logic [7:0] v;
    wr_reg(2'd0, 8'h00);
    rd_reg(2'd0, v);
    chk(v, 8'h0B, "R5 zero write keeps flags");
  endtask

  task automatic t_clear;
    logic [7:0] v;
    wr_reg(2'd1, 8'hF2);
    rd_reg(2'd0, v);
    chk(v, 8'h09, "R6 clear B only, upper bits ignored");
    rd_reg(2'd1, v);
    chk(v, 8'h00, "R6 clear register reads zero");
  endtask

  task automatic t_enable_irq;
    logic [7:0] v;
    wr_reg(2'd0, 8'h10);
    rd_reg(2'd0, v);
    chk(v, 8'h19, "R10 R2 enable A readback");
    chk({7'd0, irq_out}, 8'h00, "R9 irq not yet registered");
    @(negedge clk);
    chk({7'd0, irq_out}, 8'h01, "R9 irq one clock later");
    wr_reg(2'd0, 8'h00);
    chk({7'd0, irq_out}, 8'h01, "R9 irq lags enable drop");
    @(negedge clk);
    chk({7'd0, irq_out}, 8'h00, "R10 enable drop clears irq");
    rd_reg(2'd0, v);
    chk(v, 8'h09, "R10 flags survive enable drop");
  endtask

  task automatic t_set_wins;
    logic [7:0] v;
    @(negedge clk);
    evt_pulse = 4'b0100; bus_addr = 2'd1; bus_wr = 1'b1; bus_wdata = 8'h04;
    @(negedge clk);
    evt_pulse = '0; bus_wr = 1'b0; bus_wdata = '0;
    rd_reg(2'd0, v);
    chk(v, 8'h0D, "R7 event beats same-cycle clear");
  endtask

  task automatic t_unmapped;
    logic [7:0] v;
    wr_reg(2'd2, 8'hFF);
    wr_reg(2'd3, 8'hFF);
    rd_reg(2'd0, v);
    chk(v, 8'h0D, "R11 unmapped writes ignored");
    rd_reg(2'd2, v);
    chk(v, 8'h00, "R11 offset 2 reads zero");
    rd_reg(2'd3, v);
    chk(v, 8'h00, "R11 offset 3 reads zero");
  endtask

  task automatic t_late_event;
    logic [7:0] v;
    wr_reg(2'd0, 8'h20);
    @(negedge clk);
    chk({7'd0, irq_out}, 8'h00, "R8 enabled B with no flag stays quiet");
    pulse(4'b0010);
    rd_reg(2'd0, v);
    chk(v, 8'h2F, "R3 event sets B");
    chk({7'd0, irq_out}, 8'h00, "R9 irq still lagging");
    @(negedge clk);
    chk({7'd0, irq_out}, 8'h01, "R9 irq from enabled B");
    wr_reg(2'd1, 8'h0F);
    rd_reg(2'd0, v);
    chk(v, 8'h20, "R6 clear all flags");
    @(negedge clk);
    chk({7'd0, irq_out}, 8'h00, "R9 irq drops after clear");
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_event_disabled;
    t_sw_set;
    t_write_zero;
    t_clear;
    t_enable_irq;
    t_set_wins;
    t_unmapped;
    t_late_event;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule